// File: doc/BRIEF.md
# Machine-Mode Performance Counter Bank

This block holds the machine-mode performance counters of a small in-order RISC-V core. It always has a 64-bit cycle counter and a 64-bit retired-instruction counter. A parameter sets how many 64-bit event counters it also has, from 0 to 29. Each event counter has its own event selector register. A shared inhibit register can stop each counter on its own. The pipeline sends the block a vector of 16 single-cycle event pulses. Each counter adds one in every cycle in which its condition holds and its inhibit bit is clear.

Software reaches the bank through a plain CSR access port. The port carries a 12-bit address, 32-bit write data and a 2-bit operation. Read data is a combinational function of the address and the current register state. Set and clear operations act on the value that is read in the same cycle. Each counter is seen as two 32-bit halves at separate addresses. The port has no handshake. An access is taken in the cycle it is presented and can never be refused, so there is no back-pressure.

Top module: `perf_ctr_bank`

## Requirements
- R1: The cycle counter (index 0) adds one on every clock edge while inhibit bit 0 is clear.
- R2: The instruction counter (index 2) adds one on each edge where event bit 1 (instruction retired) is high and inhibit bit 2 is clear.
- R3: Event counter k, for k from 3 to 2+NUM_EVT_CTR, has a 16-bit selector at address 0x320+k. It adds one on each edge where the selector ANDed with the event vector is nonzero and inhibit bit k is clear. A zero selector never counts. The event bits are: 0 cycle, 1 retired, 2 compressed retired, 3 jump, 4 branch, 5 branch taken, 6 interrupt taken, 7 data read, 8 data write, 9-12 stage underuse, 13 load-use stall, 14 jump-register stall, 15 writeback stall.
- R4: Bits 31:0 of counter k are at address 0xB00+k and bits 63:32 are at 0xB80+k. Reading never changes any counter.
- R5: Reset clears every counter and selector. It sets the inhibit register (address 0x320) to a 1 in every implemented bit: 0, 2 and 3 to 2+NUM_EVT_CTR.
- R6: Counters, selectors and inhibit bits that are not implemented, including counter 1 and inhibit bit 1, always read 0, and writes to them have no effect.
- R7: The operation codes are 0 none, 1 write, 2 set and 3 clear. Set ORs the write data into the read value and clear ANDs its inverse into that value. A set or clear with zero data writes nothing.
- R8: When a counter half is written in the same cycle that the counter would increment, the written value is stored. The counter does not increment in that cycle.
- R9: A carry out of bits 31:0 reaches bits 63:32 in the same cycle.
- R10: A counter whose inhibit bit is set keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | Operation: 0 none, 1 write, 2 set, 3 clear |
| csr_wdata | input | 32 | Write or mask data |
| csr_rdata | output | 32 | Read data for csr_addr |
| evt_i | input | 16 | Single-cycle event pulses |

## Verification
A counter increment and a software write to the same counter half can land on the same edge. This can happen, for example, when a half of a running cycle counter is written, or when an event counter is rewritten in the same cycle its selected event pulses. The bench provokes this by writing halves and issuing set/clear operations while counting is enabled and events are active. A carry from the low half into the high half also coincides with increments; the bench sets low halves just below wrap to provoke it. A behavioural model applies the rule that the write wins and that the counter skips that increment. The model compares the read port on every cycle, so a lost write or an extra count shows up as a mismatch.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int CTR_W    = 64;
  localparam int HALF_W   = CTR_W / 2;
  localparam int N_EVT    = 16;
  localparam int N_SLOT   = 32;
  localparam int EVT_INSTR = 1;

  localparam logic [11:0] ADDR_INHIBIT = 12'h320;
  localparam logic [6:0]  PAGE_SEL     = 7'h19;  // 0x320..0x33F
  localparam logic [6:0]  PAGE_CNT_LO  = 7'h58;  // 0xB00..0xB1F
  localparam logic [6:0]  PAGE_CNT_HI  = 7'h5C;  // 0xB80..0xB9F

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  typedef struct packed {
    logic       cnt_lo;
    logic       cnt_hi;
    logic       sel;
    logic       inh;
    logic [4:0] idx;
  } csr_dec_t;

  function automatic logic [31:0] apply_op(input logic [1:0] op,
                                           input logic [31:0] cur,
                                           input logic [31:0] data);
    case (op)
      OP_WRITE: apply_op = data;
      OP_SET:   apply_op = cur | data;
      OP_CLEAR: apply_op = cur & ~data;
      default:  apply_op = cur;
    endcase
  endfunction

  function automatic logic is_write(input logic [1:0] op, input logic [31:0] data);
    is_write = (op == OP_WRITE) || ((op != OP_NONE) && (data != '0));
  endfunction
endpackage

// File: rtl/perf_csr_dec.sv
module perf_csr_dec
  import perf_pkg::*;
(
  input  logic [11:0] addr,
  output csr_dec_t    dec
);
  logic [6:0] page;
  assign page = addr[11:5];

  always_comb begin
    dec        = '0;
    dec.idx    = addr[4:0];
    dec.cnt_lo = (page == PAGE_CNT_LO);
    dec.cnt_hi = (page == PAGE_CNT_HI);
    dec.inh    = (addr == ADDR_INHIBIT);
    dec.sel    = (page == PAGE_SEL) && (addr[4:0] >= 5'd3);
  end
endmodule

// File: rtl/perf_cnt64.sv
module perf_cnt64 #(
  parameter int W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [W/2-1:0]   wval,
  output logic [W-1:0]     cnt
);
  localparam int H = W / 2;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt_q[H-1:0] <= wval;
      if (wr_hi) cnt_q[W-1:H] <= wval;
    end else if (inc) begin
      cnt_q <= cnt_inc;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/perf_evt_sel.sv
module perf_evt_sel #(
  parameter int NE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [NE-1:0] wval,
  input  logic [NE-1:0] evt,
  output logic [NE-1:0] sel,
  output logic          hit
);
  logic [NE-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sel_q <= '0;
    else if (wr) sel_q <= wval;
  end

  assign sel = sel_q;
  assign hit = |(sel_q & evt);
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import perf_pkg::*;
#(
  parameter int NUM_EVT_CTR = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] csr_addr,
  input  logic [1:0]  csr_op,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic [15:0] evt_i
);
  localparam logic [31:0] EVT_MASK  = ((32'h1 << NUM_EVT_CTR) - 32'h1) << 3;
  localparam logic [31:0] IMPL_MASK = 32'h5 | EVT_MASK;

  csr_dec_t          dec;
  logic [31:0]       rd_val;
  logic [31:0]       wval;
  logic              wr_any;
  logic [31:0]       inh_q;
  logic [CTR_W-1:0]  cnt_val [N_SLOT];
  logic [N_EVT-1:0]  sel_val [N_SLOT];
  logic              hit     [N_SLOT];

  perf_csr_dec u_dec (
    .addr (csr_addr),
    .dec  (dec)
  );

  always_comb begin
    rd_val = '0;
    if (dec.inh)    rd_val = inh_q;
    if (dec.sel)    rd_val = {{(32-N_EVT){1'b0}}, sel_val[dec.idx]};
    if (dec.cnt_lo) rd_val = cnt_val[dec.idx][HALF_W-1:0];
    if (dec.cnt_hi) rd_val = cnt_val[dec.idx][CTR_W-1:HALF_W];
  end

  assign csr_rdata = rd_val;
  assign wval      = apply_op(csr_op, rd_val, csr_wdata);
  assign wr_any    = is_write(csr_op, csr_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                inh_q <= IMPL_MASK;
    else if (wr_any && dec.inh) inh_q <= wval & IMPL_MASK;
  end

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    logic wr_lo, wr_hi;
    assign wr_lo = wr_any && dec.cnt_lo && (dec.idx == 5'(g));
    assign wr_hi = wr_any && dec.cnt_hi && (dec.idx == 5'(g));

    if (g == 0 || g == 2) begin : g_fixed
      assign sel_val[g] = '0;
      if (g == 0) begin : g_cyc
        assign hit[g] = 1'b1;
      end else begin : g_ret
        assign hit[g] = evt_i[EVT_INSTR];
      end
    end else if (IMPL_MASK[g]) begin : g_evt
      logic sel_wr;
      assign sel_wr = wr_any && dec.sel && (dec.idx == 5'(g));
      perf_evt_sel #(.NE(N_EVT)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (sel_wr),
        .wval  (wval[N_EVT-1:0]),
        .evt   (evt_i),
        .sel   (sel_val[g]),
        .hit   (hit[g])
      );
    end else begin : g_none
      assign sel_val[g] = '0;
      assign hit[g]     = 1'b0;
      assign cnt_val[g] = '0;
    end

    if (IMPL_MASK[g]) begin : g_cnt
      perf_cnt64 #(.W(CTR_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (hit[g] && !inh_q[g]),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wval  (wval),
        .cnt   (cnt_val[g])
      );
    end
  end
endmodule

// File: rtl/perf_ctr_bank_chk.sv
module perf_ctr_bank_chk
  import perf_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] csr_addr,
  input logic [1:0]  csr_op,
  input logic [31:0] csr_wdata,
  input logic [31:0] csr_rdata,
  input logic [15:0] evt_i,
  input logic [31:0] inh_q,
  input logic [63:0] cyc_q,
  input logic [63:0] ins_q
);
  logic wr_op, cyc_wr, ins_wr;
  assign wr_op  = (csr_op == OP_WRITE) || (csr_op != OP_NONE && csr_wdata != 32'h0);
  assign cyc_wr = wr_op && (csr_addr == 12'hB00 || csr_addr == 12'hB80);
  assign ins_wr = wr_op && (csr_addr == 12'hB02 || csr_addr == 12'hB82);

  p_cycle_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!inh_q[0] && !cyc_wr) |=> (cyc_q == $past(cyc_q) + 64'd1));

  p_instret_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inh_q[2] && evt_i[1] && !ins_wr) |=> (ins_q == $past(ins_q) + 64'd1));

  p_instret_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i[1] && !ins_wr) |=> $stable(ins_q));

  p_unimpl_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == 12'hB01 || csr_addr == 12'hB81) |-> (csr_rdata == 32'h0));

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_op == OP_WRITE && csr_addr == 12'hB00) |=> (cyc_q[31:0] == $past(csr_wdata)));

  p_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!inh_q[0] && !cyc_wr && cyc_q[31:0] == 32'hFFFF_FFFF)
    |=> (cyc_q[31:0] == 32'h0 && cyc_q[63:32] == $past(cyc_q[63:32]) + 32'd1));

  p_inhibit_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q[0] && !cyc_wr) |=> $stable(cyc_q));
endmodule

bind perf_ctr_bank perf_ctr_bank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csr_addr  (csr_addr),
  .csr_op    (csr_op),
  .csr_wdata (csr_wdata),
  .csr_rdata (csr_rdata),
  .evt_i     (evt_i),
  .inh_q     (inh_q),
  .cyc_q     (cnt_val[0]),
  .ins_q     (cnt_val[2])
);

// File: tb/sim_perf_ctr_bank.sv
`timescale 1ns/1ps
module sim_perf_ctr_bank;
  localparam int NEV = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  csr_op = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic [15:0] evt_i = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  longint unsigned m_cnt [32];
  int unsigned     m_sel [32];
  int unsigned     m_inh;

  always #4 clk = ~clk;

  perf_ctr_bank #(.NUM_EVT_CTR(NEV)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_addr  (csr_addr),
    .csr_op    (csr_op),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .evt_i     (evt_i)
  );

  function automatic bit impl(input int k);
    return (k == 0) || (k == 2) || (k >= 3 && k < 3 + NEV);
  endfunction

  function automatic int unsigned mask_all();
    int unsigned m = 0;
    for (int k = 0; k < 32; k++) if (impl(k)) m |= (32'h1 << k);
    return m;
  endfunction

  function automatic int unsigned m_read(input logic [11:0] a);
    int k = int'(a[4:0]);
    if (a == 12'h320) return m_inh;
    if (a[11:5] == 7'h19 && k >= 3) return impl(k) ? m_sel[k] : 0;
    if (a[11:5] == 7'h58) return impl(k) ? m_cnt[k][31:0] : 0;
    if (a[11:5] == 7'h5C) return impl(k) ? m_cnt[k][63:32] : 0;
    return 0;
  endfunction

  task automatic m_reset();
    for (int k = 0; k < 32; k++) begin m_cnt[k] = 0; m_sel[k] = 0; end
    m_inh = mask_all();
  endtask

  task automatic m_update(input logic [11:0] a, input logic [1:0] op,
                          input logic [31:0] d, input logic [15:0] ev);
    int unsigned cur = m_read(a);
    int unsigned nv;
    bit wr = (op == 2'd1) || (op != 2'd0 && d != 0);
    int k = int'(a[4:0]);
    bit skip [32];
    case (op)
      2'd1: nv = d;
      2'd2: nv = cur | d;
      2'd3: nv = cur & ~d;
      default: nv = cur;
    endcase
    for (int j = 0; j < 32; j++) skip[j] = 0;
    if (wr && (a[11:5] == 7'h58 || a[11:5] == 7'h5C) && impl(k)) skip[k] = 1;
    // increments on pre-write state
    for (int j = 0; j < 32; j++) begin
      bit fire = 0;
      if (!impl(j) || skip[j] || m_inh[j]) continue;
      if (j == 0) fire = 1;
      else if (j == 2) fire = ev[1];
      else fire = (m_sel[j] & ev) != 0;
      if (fire) m_cnt[j] = m_cnt[j] + 1;
    end
    if (wr) begin
      if (a == 12'h320) m_inh = nv & mask_all();
      else if (a[11:5] == 7'h19 && k >= 3 && impl(k)) m_sel[k] = nv & 32'hFFFF;
      else if (a[11:5] == 7'h58 && impl(k)) m_cnt[k][31:0] = nv;
      else if (a[11:5] == 7'h5C && impl(k)) m_cnt[k][63:32] = nv;
    end
  endtask

  task automatic step(input logic [11:0] a, input logic [1:0] op,
                      input logic [31:0] d, input logic [15:0] ev, input string tag);
    int unsigned exp;
    @(negedge clk);
    csr_addr = a; csr_op = op; csr_wdata = d; evt_i = ev;
    #2;
    exp = m_read(a);
    total++;
    if (csr_rdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, a, csr_rdata, exp);
    end
    m_update(a, op, d, ev);
  endtask

  task automatic rd(input logic [11:0] a, input logic [15:0] ev, input string tag);
    step(a, 2'd0, 32'h0, ev, tag);
  endtask

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R5: reset state
    rd(12'h320, 16'h0, "R5");
    rd(12'hB00, 16'h0, "R5");
    rd(12'hB82, 16'h0, "R5");
    rd(12'h323, 16'h0, "R5");
    rd(12'hB03, 16'hFFFF, "R5");

    // R10 / R4: inhibited counters hold, reads do not disturb
    for (int i = 0; i < 4; i++) rd(12'hB00, 16'hFFFF, "R10");
    for (int i = 0; i < 3; i++) rd(12'hB02, 16'h0002, "R4");

    // R7: clear inhibit bits 0 and 2
    step(12'h320, 2'd3, 32'h5, 16'h0, "R7");
    for (int i = 0; i < 5; i++) rd(12'hB00, 16'h0, "R1");
    rd(12'hB80, 16'h0, "R4");

    // R2: instruction counter follows event bit 1
    for (int i = 0; i < 8; i++) rd(12'hB02, (i % 3 == 0) ? 16'h0002 : 16'h0FFD, "R2");

    // R3: event counter 3 on taken branches (bit 5)
    step(12'h323, 2'd1, 32'h0000_0020, 16'h0, "R3");
    step(12'h320, 2'd3, 32'h8, 16'h0, "R7");
    for (int i = 0; i < 10; i++) rd(12'hB03, (i % 2) ? 16'h0020 : 16'h0010, "R3");
    // R3: other event positions (data write bit 8)
    step(12'h323, 2'd1, 32'h0000_0100, 16'h0100, "R3");
    for (int i = 0; i < 6; i++) rd(12'hB03, (i < 4) ? 16'h0100 : 16'h0000, "R3");
    // R3: zero selector never counts
    step(12'h323, 2'd1, 32'h0, 16'hFFFF, "R3");
    for (int i = 0; i < 5; i++) rd(12'hB03, 16'hFFFF, "R3");
    rd(12'h323, 16'h0, "R3");

    // R9: carry into high half, cycle and event counters
    step(12'hB00, 2'd1, 32'hFFFF_FFFD, 16'h0, "R8");
    for (int i = 0; i < 4; i++) rd(12'hB00, 16'h0, "R9");
    rd(12'hB80, 16'h0, "R9");
    step(12'h323, 2'd1, 32'h1, 16'h0, "R3");
    step(12'hB03, 2'd1, 32'hFFFF_FFFF, 16'h1, "R8");
    rd(12'hB03, 16'h1, "R9");
    rd(12'hB83, 16'h1, "R9");

    // R8: write wins over a coincident increment
    step(12'hB80, 2'd1, 32'h1234_5678, 16'h0, "R8");
    rd(12'hB80, 16'h0, "R8");
    step(12'hB02, 2'd1, 32'h0000_0100, 16'h0002, "R8");
    rd(12'hB02, 16'h0002, "R8");
    step(12'hB03, 2'd1, 32'h0000_0040, 16'h0001, "R8");
    rd(12'hB03, 16'h0001, "R8");

    // R7: set/clear on counter halves, zero-data set is not a write
    step(12'hB82, 2'd2, 32'hF000_0000, 16'h0002, "R7");
    rd(12'hB82, 16'h0, "R7");
    step(12'hB82, 2'd3, 32'h3000_0000, 16'h0, "R7");
    rd(12'hB82, 16'h0, "R7");
    step(12'hB00, 2'd2, 32'h0, 16'h0, "R7");
    rd(12'hB00, 16'h0, "R7");
    step(12'hB00, 2'd3, 32'h0, 16'h0, "R7");
    rd(12'hB00, 16'h0, "R7");

    // R6: unimplemented locations
    step(12'hB04, 2'd1, 32'hFFFF_FFFF, 16'hFFFF, "R6");
    rd(12'hB04, 16'hFFFF, "R6");
    step(12'hB84, 2'd1, 32'hAAAA_5555, 16'h0, "R6");
    rd(12'hB84, 16'h0, "R6");
    step(12'h324, 2'd1, 32'hFFFF, 16'h0, "R6");
    rd(12'h324, 16'h0, "R6");
    step(12'hB01, 2'd1, 32'h7, 16'h0, "R6");
    rd(12'hB01, 16'h0, "R6");
    rd(12'hB81, 16'h0, "R6");
    step(12'h320, 2'd2, 32'hFFFF_FFFF, 16'h0, "R6");
    rd(12'h320, 16'h0, "R6");

    // R10: all inhibited again, values held
    for (int i = 0; i < 3; i++) rd(12'hB00, 16'hFFFF, "R10");
    rd(12'hB03, 16'hFFFF, "R10");
    rd(12'hB02, 16'hFFFF, "R10");
    step(12'h320, 2'd1, 32'h0, 16'h0, "R7");
    rd(12'hB00, 16'h0, "R1");
    rd(12'hB00, 16'h0, "R1");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule